// File: doc/BRIEF.md
# Per-Output Knockout Filter and Concentrator

This block is the slice of a single-stage knockout cell switch that belongs to one switch output. Every time slot, each of the N switch inputs may offer one cell: a valid bit, a destination output address and a payload word. A filter bank keeps only the valid cells whose address equals this output's index. A concentrator then packs the surviving cells onto L output lanes, with no gaps, starting at lane 0. When more than L cells survive, the lowest-numbered inputs win and the surplus is knocked out. Losing cells are discarded; there is no backpressure.

The lanes are meant to feed the output buffering stage that follows. For each slot the block also reports how many cells were discarded. It keeps a saturating cumulative loss total that can be cleared synchronously. All results are registered and appear one clock after the slot is sampled.

Top module: `ko_out_port`

## Requirements
- R1: An input cell reaches the concentrator only when its valid bit is 1 and its destination field (input i uses bits [i*ADDR_W +: ADDR_W] of `cell_dst_i`) equals `PORT_ADDR`. All other cells have no effect on the lanes, the drop count or the loss total.
- R2: If k cells pass the filter in a slot and k <= L, then lanes 0..k-1 have their valid bit set and lanes k..L-1 have it clear.
- R3: If k > L, all L lane valid bits are set and `drop_cnt_o` equals k - L.
- R4: If k <= L, `drop_cnt_o` is 0.
- R5: Lane j (bits [j*DATA_W +: DATA_W] of `lane_data_o`) carries the payload of the passing cell with the j-th lowest input index (input i payload is bits [i*DATA_W +: DATA_W] of `cell_data_i`). Winners are therefore the lowest-indexed passing inputs, and their input order is kept across the lanes.
- R6: The lanes and `drop_cnt_o` reflect the cells sampled at the previous rising clock edge, and they change only at a clock edge.
- R7: Each slot's lanes and drop count depend only on that slot's arrivals. Nothing is carried over from earlier slots.
- R8: `loss_total_o` accumulates the drops of every slot. The slot shown on `drop_cnt_o` is already included. The total saturates at 2^LOSS_W - 1 and never wraps.
- R9: When `loss_clr_i` is 1 at a clock edge, `loss_total_o` becomes 0 at that edge, and the drops of that slot are not counted.
- R10: While `rst_ni` is low, all lane valid bits, `drop_cnt_o` and `loss_total_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_vld_i | input | N_IN | Per-input cell valid |
| cell_dst_i | input | N_IN*ADDR_W | Per-input destination address |
| cell_data_i | input | N_IN*DATA_W | Per-input payload |
| loss_clr_i | input | 1 | Synchronous clear of the loss total |
| lane_vld_o | output | L_OUT | Per-lane valid, packed from lane 0 |
| lane_data_o | output | L_OUT*DATA_W | Per-lane payload |
| drop_cnt_o | output | $clog2(N_IN+1) | Cells knocked out in the slot |
| loss_total_o | output | LOSS_W | Saturating cumulative loss |

## Verification
The bench targets the boundary loads k=0, k=L, k=L+1 and k=N. A faulty concentrator would leave a gap in the lanes, drop one cell too many or too few, or let a high input displace a low one. Cells that carry a matching address but a cleared valid bit, and valid cells addressed elsewhere, are mixed in. A filter that tests only one of the two conditions would then put extra cells on the lanes. An overflow slot followed by an empty one exposes any state carried between slots. A clear issued together with a dropping slot, and a narrow loss counter driven past its limit, expose an adder that counts the clearing slot or wraps to zero.

// File: rtl/ko_pkg.sv
package ko_pkg;
  localparam int unsigned KO_LOSS_W = 32;

  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ko_addr_filter.sv
module ko_addr_filter #(
  parameter int unsigned N_IN      = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned PORT_ADDR = 5
) (
  input  logic [N_IN-1:0]        vld_i,
  input  logic [N_IN*ADDR_W-1:0] dst_i,
  output logic [N_IN-1:0]        pass_o
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PORT_ADDR);

  for (genvar i = 0; i < N_IN; i++) begin : g_flt
    assign pass_o[i] = vld_i[i] && (dst_i[i*ADDR_W +: ADDR_W] == MY_ADDR);
  end
endmodule

// File: rtl/ko_concentrator.sv
module ko_concentrator
  import ko_pkg::*;
#(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned L_OUT  = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = cnt_width(N_IN)
) (
  input  logic [N_IN-1:0]         pass_i,
  input  logic [N_IN*DATA_W-1:0]  data_i,
  output logic [L_OUT-1:0]        lane_vld_o,
  output logic [L_OUT*DATA_W-1:0] lane_data_o,
  output logic [CNT_W-1:0]        hit_cnt_o,
  output logic [CNT_W-1:0]        drop_o
);
  localparam logic [CNT_W-1:0] L_CNT = CNT_W'(L_OUT);

  logic [CNT_W-1:0] rank [N_IN];
  logic [CNT_W-1:0] run;

  // rank[i] = number of passing cells on inputs below i
  always_comb begin
    run = '0;
    for (int i = 0; i < N_IN; i++) begin
      rank[i] = run;
      run     = run + CNT_W'(pass_i[i]);
    end
    hit_cnt_o = run;
  end

  assign drop_o = (hit_cnt_o > L_CNT) ? (hit_cnt_o - L_CNT) : '0;

  for (genvar j = 0; j < L_OUT; j++) begin : g_lane
    logic              sel_vld;
    logic [DATA_W-1:0] sel_dat;
    always_comb begin
      sel_vld = 1'b0;
      sel_dat = '0;
      for (int i = 0; i < N_IN; i++) begin
        if (pass_i[i] && rank[i] == CNT_W'(j)) begin
          sel_vld = 1'b1;
          sel_dat = data_i[i*DATA_W +: DATA_W];
        end
      end
    end
    assign lane_vld_o[j]                   = sel_vld;
    assign lane_data_o[j*DATA_W +: DATA_W] = sel_dat;
  end
endmodule

// File: rtl/ko_loss_counter.sv
module ko_loss_counter #(
  parameter int unsigned LOSS_W = 32,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [CNT_W-1:0]  add_i,
  output logic [LOSS_W-1:0] total_o
);
  localparam logic [LOSS_W-1:0] SAT_MAX = '1;

  logic [LOSS_W:0] sum;
  assign sum = {1'b0, total_o} + (LOSS_W+1)'(add_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       total_o <= '0;
    else if (clr_i)    total_o <= '0;
    else if (sum[LOSS_W]) total_o <= SAT_MAX;
    else               total_o <= sum[LOSS_W-1:0];
  end

  a_r9_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (total_o == '0));

  a_r8_no_decrease: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (total_o >= $past(total_o)));

  a_r8_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && total_o == SAT_MAX) |=> (total_o == SAT_MAX));
endmodule

// File: rtl/ko_out_port.sv
module ko_out_port
  import ko_pkg::*;
#(
  parameter int unsigned N_IN      = 8,
  parameter int unsigned L_OUT     = 4,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PORT_ADDR = 5,
  parameter int unsigned LOSS_W    = KO_LOSS_W,
  localparam int unsigned CNT_W    = cnt_width(N_IN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_IN-1:0]         cell_vld_i,
  input  logic [N_IN*ADDR_W-1:0]  cell_dst_i,
  input  logic [N_IN*DATA_W-1:0]  cell_data_i,
  input  logic                    loss_clr_i,
  output logic [L_OUT-1:0]        lane_vld_o,
  output logic [L_OUT*DATA_W-1:0] lane_data_o,
  output logic [CNT_W-1:0]        drop_cnt_o,
  output logic [LOSS_W-1:0]       loss_total_o
);
  logic [N_IN-1:0]         pass;
  logic [L_OUT-1:0]        c_vld;
  logic [L_OUT*DATA_W-1:0] c_data;
  logic [CNT_W-1:0]        hit_cnt;
  logic [CNT_W-1:0]        c_drop;

  ko_addr_filter #(
    .N_IN(N_IN), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)
  ) u_filter (
    .vld_i(cell_vld_i), .dst_i(cell_dst_i), .pass_o(pass)
  );

  ko_concentrator #(
    .N_IN(N_IN), .L_OUT(L_OUT), .DATA_W(DATA_W)
  ) u_conc (
    .pass_i(pass), .data_i(cell_data_i), .lane_vld_o(c_vld),
    .lane_data_o(c_data), .hit_cnt_o(hit_cnt), .drop_o(c_drop)
  );

  ko_loss_counter #(
    .LOSS_W(LOSS_W), .CNT_W(CNT_W)
  ) u_loss (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(loss_clr_i),
    .add_i(c_drop), .total_o(loss_total_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_vld_o  <= '0;
      lane_data_o <= '0;
      drop_cnt_o  <= '0;
    end else begin
      lane_vld_o  <= c_vld;
      lane_data_o <= c_data;
      drop_cnt_o  <= c_drop;
    end
  end

  // lanes form a contiguous run from lane 0
  a_r2_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (({1'b0, lane_vld_o} & ({1'b0, lane_vld_o} + 1'b1)) == '0));

  a_r3_full_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != '0) |-> (&lane_vld_o));

  a_r3_conserve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($countones(lane_vld_o) + int'(drop_cnt_o)) == $past(int'(hit_cnt))));

  a_r1_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_vld_i == '0) |=> (lane_vld_o == '0 && drop_cnt_o == '0));
endmodule

// File: tb/ko_out_port_bench.sv
module ko_out_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int L    = 4;
  localparam int AW   = 3;
  localparam int DW   = 16;
  localparam int PORT = 5;
  localparam int CW   = 4;
  localparam int SW   = 4;
  localparam int NV   = 11;

  // valid mask / address-hit mask per vector (R1: hit means dst==PORT)
  localparam logic [7:0] TV_VLD [NV] = '{8'h00, 8'hFF, 8'h0F, 8'hFF, 8'hFF, 8'hA5,
                                         8'h80, 8'hFF, 8'h3C, 8'hFF, 8'h7F};
  localparam logic [7:0] TV_HIT [NV] = '{8'h00, 8'h00, 8'hFF, 8'h1F, 8'hFF, 8'hFF,
                                         8'h80, 8'h96, 8'hF0, 8'h0E, 8'hFE};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]    cell_vld = '0;
  logic [N*AW-1:0] cell_dst = '0;
  logic [N*DW-1:0] cell_data = '0;
  logic            loss_clr = 1'b0;
  logic [L-1:0]    lane_vld, lane_vld_s;
  logic [L*DW-1:0] lane_data, lane_data_s;
  logic [CW-1:0]   drop_cnt, drop_cnt_s;
  logic [31:0]     loss_total;
  logic [SW-1:0]   loss_total_s;

  int n_chk = 0;
  int n_err = 0;
  longint m_total = 0;
  longint m_sat = 0;
  logic [L-1:0]  e_vld;
  logic [DW-1:0] e_dat [L];
  int            e_drop;

  always #(CLK_PERIOD/2) clk = ~clk;

  ko_out_port #(.N_IN(N), .L_OUT(L), .ADDR_W(AW), .DATA_W(DW), .PORT_ADDR(PORT))
  u_ko_out_port (
    .clk_i(clk), .rst_ni(rst_ni), .cell_vld_i(cell_vld), .cell_dst_i(cell_dst),
    .cell_data_i(cell_data), .loss_clr_i(loss_clr), .lane_vld_o(lane_vld),
    .lane_data_o(lane_data), .drop_cnt_o(drop_cnt), .loss_total_o(loss_total)
  );

  ko_out_port #(.N_IN(N), .L_OUT(L), .ADDR_W(AW), .DATA_W(DW), .PORT_ADDR(PORT),
                .LOSS_W(SW))
  u_ko_out_port_sat (
    .clk_i(clk), .rst_ni(rst_ni), .cell_vld_i(cell_vld), .cell_dst_i(cell_dst),
    .cell_data_i(cell_data), .loss_clr_i(loss_clr), .lane_vld_o(lane_vld_s),
    .lane_data_o(lane_data_s), .drop_cnt_o(drop_cnt_s), .loss_total_o(loss_total_s)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, build expected result from the requirements
  task automatic drive(input logic [7:0] vld, input logic [7:0] hit, input int tag);
    int k = 0;
    for (int i = 0; i < N; i++) begin
      cell_vld[i] = vld[i];
      cell_dst[i*AW +: AW] = hit[i] ? AW'(PORT) : AW'(PORT ^ (1 + (i % 7)));
      cell_data[i*DW +: DW] = {8'(tag), 8'(i)};
    end
    e_vld = '0;
    for (int j = 0; j < L; j++) e_dat[j] = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && hit[i]) begin
        if (k < L) begin
          e_vld[k] = 1'b1;
          e_dat[k] = {8'(tag), 8'(i)};
        end
        k++;
      end
    end
    e_drop = (k > L) ? k - L : 0;
  endtask

  task automatic step();
    @(posedge clk);
    if (loss_clr) begin
      m_total = 0;
      m_sat = 0;
    end else begin
      m_total = m_total + e_drop;
      m_sat = (m_sat + e_drop > 15) ? 15 : m_sat + e_drop;
    end
    @(negedge clk);
  endtask

  task automatic check_slot(input string tagname);
    for (int j = 0; j < L; j++) begin
      chk({"R2 lane valid ", tagname}, lane_vld[j], e_vld[j]);
      if (e_vld[j]) chk({"R5 lane payload ", tagname}, lane_data[j*DW +: DW], e_dat[j]);
    end
    chk({"R3/R4 drop ", tagname}, drop_cnt, e_drop);
    chk({"R8 loss total ", tagname}, loss_total, m_total);
    chk({"R8 sat total ", tagname}, loss_total_s, m_sat);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R10 reset lanes", lane_vld, 0);
    chk("R10 reset drop", drop_cnt, 0);
    chk("R10 reset total", loss_total, 0);
    m_total = 0;
    m_sat = 0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog act=1 exp=0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    do_reset();

    // table walk: k=0, k=0 misaddressed, R1 invalid-but-matching, k=L+1, k=N, ...
    for (int v = 0; v < NV; v++) begin
      drive(TV_VLD[v], TV_HIT[v], v);
      step();
      check_slot($sformatf("R1 vec%0d", v));
    end

    // R6: output holds until the edge
    drive(8'h00, 8'h00, 20);
    step();
    drive(8'h07, 8'hFF, 21);
    #1;
    chk("R6 no change before edge", lane_vld, 0);
    step();
    check_slot("R6 after edge");

    // R7: overflow then empty slot
    drive(8'hFF, 8'hFF, 22);
    step();
    check_slot("R7 overflow");
    drive(8'h00, 8'hFF, 23);
    step();
    check_slot("R7 empty after overflow");

    // R9: clear together with a dropping slot
    drive(8'hFF, 8'hFF, 24);
    loss_clr = 1'b1;
    step();
    chk("R9 clear wins", loss_total, 0);
    chk("R9 clear sat", loss_total_s, 0);
    loss_clr = 1'b0;
    chk("R3 drop during clear", drop_cnt, 4);

    // R8: drive narrow counter into saturation
    for (int s = 0; s < 6; s++) begin
      drive(8'hFF, 8'hFF, 30 + s);
      step();
      check_slot($sformatf("R8 sat%0d", s));
    end
    chk("R8 saturated", loss_total_s, 15);

    // random loads
    for (int r = 0; r < 300; r++) begin
      logic [7:0] rv, rh;
      rv = 8'($urandom);
      rh = 8'($urandom) | 8'($urandom);
      drive(rv, rh, 64 + (r % 150));
      step();
      check_slot("R5 random");
    end

    do_reset();
    #1;
    chk("R10 reset sat total", loss_total_s, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule